// File: doc/BRIEF.md
# Power-on configuration loader sequencer

This block brings a working configuration RAM up to date from one-time-programmable (OTP) storage after the supply becomes valid. It first keeps the conditioned output switched off for a start-up hold time. A static instant-on configuration bit skips that hold. It then reads four write-once bank-selector slots, picks the active bank from the highest-numbered slot that holds a programmed value, and reads that bank of data words together with its stored checksum word.

Only when the 8-bit sum of the data words equals the stored checksum does it copy the bank into the configuration RAM and raise the output-enable flag. A mismatch leaves RAM untouched and the output disabled, and raises an error status. Every run ends with a one-cycle completion pulse. Other logic can ask for a fresh load later with a reload request. The supply-valid detector is an input that acts as an asynchronous active-low reset of every register.

The OTP read port and the RAM write port are valid/ready streams. A request, or a write, stays asserted with unchanged address and data until the cycle in which ready is high; that cycle is the transfer. Only one OTP read is outstanding at a time. The OTP side returns exactly one `otp_rsp_valid` cycle per accepted request, at any later cycle. The block always accepts that response, so the response path has no ready.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `supply_ok` is low, `out_en`, `done`, `csum_err`, `otp_req_valid` and `cfg_wr_valid` are all 0.
- R2: With `instant_on` at 0, the first OTP request becomes visible exactly DELAY_CYC clock edges after `supply_ok` rises, and `out_en` stays 0 until then.
- R3: With `instant_on` at 1, the first OTP request becomes visible after the first clock edge following the rise of `supply_ok`.
- R4: Selector slot k (k = 1..NUM_SLOTS) sits at OTP address NUM_BANKS*(BANK_WORDS+1)+k-1. A slot counts as programmed when its value is in 1..NUM_BANKS. The programmed slot with the highest k names the active bank. Any other value, including 0 and values above NUM_BANKS, is ignored.
- R5: When no slot is programmed, bank 1 is used.
- R6: Bank b occupies OTP addresses (b-1)*(BANK_WORDS+1) upward: BANK_WORDS data words, then one checksum word. The bank is valid when the modulo-256 sum of its data words equals the checksum word.
- R7: For a valid bank, data word w is written to RAM address w, in ascending order. `done` then pulses with `out_en` = 1 and `csum_err` = 0 in the same cycle.
- R8: For an invalid bank, no RAM write occurs. `done` pulses with `csum_err` = 1 and `out_en` = 0.
- R9: An OTP request or RAM write that is not accepted keeps its valid, address and data unchanged in the next cycle.
- R10: A `reload_req` seen while idle starts a new selection without the start-up hold: a request is visible one edge later. `out_en` and `csum_err` are cleared at that edge.
- R11: `reload_req` is ignored while a sequence runs, including the cycle in which `done` is high. No extra run, pulse or status change follows.
- R12: `done` is high for exactly one cycle per completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_ok | input | 1 | Supply-valid flag, asynchronous active-low reset of all state |
| instant_on | input | 1 | Static configuration bit that skips the start-up hold |
| reload_req | input | 1 | Request for a fresh load, honoured only when idle |
| otp_req_valid | output | 1 | OTP read request valid |
| otp_req_ready | input | 1 | OTP accepts the request this cycle |
| otp_req_addr | output | AW | OTP word address |
| otp_rsp_valid | input | 1 | Read data valid, one cycle per accepted request |
| otp_rsp_data | input | DW | Read data word |
| cfg_wr_valid | output | 1 | Configuration RAM write valid |
| cfg_wr_ready | input | 1 | RAM accepts the write this cycle |
| cfg_wr_addr | output | RAW | RAM word address |
| cfg_wr_data | output | DW | RAM write data |
| out_en | output | 1 | Conditioned output enable |
| done | output | 1 | One-cycle pulse at the end of each sequence |
| csum_err | output | 1 | Last sequence found a checksum mismatch |

## Verification
The collision of interest is a reload request in the same cycle as the completion pulse. At that point the sequencer is still finishing, and it must let the request go. The bench raises `reload_req` exactly in the cycle it sees `done`, after a run that ended with a checksum error. It then watches for thirty cycles and expects no OTP request, no second pulse and a `csum_err` that is still set, since a restart would have cleared it. A request dropped in the middle of a run is judged the same way, by the count of completion pulses. Both cases hold under random back-pressure on both streams, and a scoreboard matches every RAM write against the bank the bench itself chose.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_SLOT_REQ,
    ST_SLOT_RSP,
    ST_SUM_REQ,
    ST_SUM_RSP,
    ST_COPY_REQ,
    ST_COPY_RSP,
    ST_COPY_WR,
    ST_FINISH,
    ST_IDLE
  } boot_state_e;

endpackage

// File: rtl/cfg_hold_timer.sv
module cfg_hold_timer #(
  parameter int LIMIT = 1250000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  logic [CW-1:0] cnt;

  assign expired = (cnt >= CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    expired && run |=> expired); // R2

endmodule

// File: rtl/cfg_slot_pick.sv
module cfg_slot_pick #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_BANKS = 7,
  parameter int DW        = 8,
  localparam int BKW      = $clog2(NUM_BANKS + 1)
) (
  input  logic [NUM_SLOTS-1:0][DW-1:0] slot_word,
  output logic [BKW-1:0]               bank
);

  logic [NUM_SLOTS-1:0] prog;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_prog
    assign prog[g] = (slot_word[g] != '0) && (slot_word[g] <= DW'(NUM_BANKS));
  end

  always_comb begin
    bank = BKW'(1);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (prog[i]) begin
        bank = slot_word[i][BKW-1:0];
      end
    end
  end

endmodule

// File: rtl/cfg_csum_acc.sv
module cfg_csum_acc #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] acc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clr) begin
      acc <= '0;
    end else if (add_en) begin
      acc <= acc + din;
    end
  end

  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !add_en |=> $stable(acc) || acc == '0); // R6

endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
  import cfg_boot_pkg::*;
#(
  parameter int NUM_BANKS  = 7,
  parameter int NUM_SLOTS  = 4,
  parameter int BANK_WORDS = 8,
  parameter int DW         = 8,
  parameter int DELAY_CYC  = 1250000,
  localparam int WPB       = BANK_WORDS + 1,
  localparam int SLOT_BASE = NUM_BANKS * WPB,
  localparam int AW        = $clog2(SLOT_BASE + NUM_SLOTS),
  localparam int RAW       = $clog2(BANK_WORDS),
  localparam int BKW       = $clog2(NUM_BANKS + 1),
  localparam int SIW       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int WIW       = $clog2(BANK_WORDS + 1),
  localparam int HCW       = $clog2(DELAY_CYC + 1)
) (
  input  logic           clk,
  input  logic           supply_ok,
  input  logic           instant_on,
  input  logic           reload_req,
  output logic           otp_req_valid,
  input  logic           otp_req_ready,
  output logic [AW-1:0]  otp_req_addr,
  input  logic           otp_rsp_valid,
  input  logic [DW-1:0]  otp_rsp_data,
  output logic           cfg_wr_valid,
  input  logic           cfg_wr_ready,
  output logic [RAW-1:0] cfg_wr_addr,
  output logic [DW-1:0]  cfg_wr_data,
  output logic           out_en,
  output logic           done,
  output logic           csum_err
);

  boot_state_e                  state;
  logic [SIW-1:0]               slot_idx;
  logic [WIW-1:0]               word_idx;
  logic [NUM_SLOTS-1:0][DW-1:0] slot_q;
  logic [DW-1:0]                wr_data_q;
  logic                         sum_ok_q;
  logic                         out_en_q;
  logic                         err_q;
  logic [BKW-1:0]               pick_bank;
  logic [AW-1:0]                bank_base;
  logic [DW-1:0]                acc;
  logic                         hold_over;
  logic                         last_word;
  logic                         last_slot;

  // Start-up hold timer, counting only while the sequencer waits in ST_HOLD
  cfg_hold_timer #(.LIMIT(DELAY_CYC)) u_hold (
    .clk     (clk),
    .rst_n   (supply_ok),
    .run     (state == ST_HOLD),
    .expired (hold_over)
  );

  // Priority pick across all fetched selector slots
  cfg_slot_pick #(.NUM_SLOTS(NUM_SLOTS), .NUM_BANKS(NUM_BANKS), .DW(DW)) u_pick (
    .slot_word (slot_q),
    .bank      (pick_bank)
  );

  // Running checksum over the data words of the verification pass
  cfg_csum_acc #(.DW(DW)) u_sum (
    .clk    (clk),
    .rst_n  (supply_ok),
    .clr    ((state != ST_SUM_REQ) && (state != ST_SUM_RSP)),
    .add_en ((state == ST_SUM_RSP) && otp_rsp_valid && !last_word),
    .din    (otp_rsp_data),
    .acc    (acc)
  );

  assign last_word = (word_idx == WIW'(BANK_WORDS));
  assign last_slot = (slot_idx == SIW'(NUM_SLOTS - 1));
  assign bank_base = AW'((int'(pick_bank) - 1) * WPB);

  assign otp_req_valid = (state == ST_SLOT_REQ) || (state == ST_SUM_REQ) ||
                         (state == ST_COPY_REQ);
  assign otp_req_addr  = (state == ST_SLOT_REQ) ? AW'(SLOT_BASE + int'(slot_idx))
                                                : AW'(int'(bank_base) + int'(word_idx));
  assign cfg_wr_valid  = (state == ST_COPY_WR);
  assign cfg_wr_addr   = word_idx[RAW-1:0];
  assign cfg_wr_data   = wr_data_q;
  assign out_en        = out_en_q;
  assign csum_err      = err_q;
  assign done          = (state == ST_FINISH);

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      state     <= ST_HOLD;
      slot_idx  <= '0;
      word_idx  <= '0;
      slot_q    <= '0;
      wr_data_q <= '0;
      sum_ok_q  <= 1'b0;
      out_en_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      case (state)
        ST_HOLD: begin
          if (instant_on || hold_over) begin
            state    <= ST_SLOT_REQ;
            slot_idx <= '0;
          end
        end
        ST_SLOT_REQ: begin
          sum_ok_q <= 1'b0;
          if (otp_req_ready) state <= ST_SLOT_RSP;
        end
        ST_SLOT_RSP: begin
          if (otp_rsp_valid) begin
            slot_q[slot_idx] <= otp_rsp_data;
            if (last_slot) begin
              state    <= ST_SUM_REQ;
              word_idx <= '0;
            end else begin
              state    <= ST_SLOT_REQ;
              slot_idx <= slot_idx + 1'b1;
            end
          end
        end
        ST_SUM_REQ: begin
          if (otp_req_ready) state <= ST_SUM_RSP;
        end
        ST_SUM_RSP: begin
          if (otp_rsp_valid) begin
            if (last_word) begin
              word_idx <= '0;
              if (acc == otp_rsp_data) begin
                sum_ok_q <= 1'b1;
                state    <= ST_COPY_REQ;
              end else begin
                err_q <= 1'b1;
                state <= ST_FINISH;
              end
            end else begin
              word_idx <= word_idx + 1'b1;
              state    <= ST_SUM_REQ;
            end
          end
        end
        ST_COPY_REQ: begin
          if (otp_req_ready) state <= ST_COPY_RSP;
        end
        ST_COPY_RSP: begin
          if (otp_rsp_valid) begin
            wr_data_q <= otp_rsp_data;
            state     <= ST_COPY_WR;
          end
        end
        ST_COPY_WR: begin
          if (cfg_wr_ready) begin
            if (word_idx == WIW'(BANK_WORDS - 1)) begin
              out_en_q <= 1'b1;
              state    <= ST_FINISH;
            end else begin
              word_idx <= word_idx + 1'b1;
              state    <= ST_COPY_REQ;
            end
          end
        end
        ST_FINISH: begin
          state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (reload_req) begin
            out_en_q <= 1'b0;
            err_q    <= 1'b0;
            slot_idx <= '0;
            state    <= ST_SLOT_REQ;
          end
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  // Cycles elapsed since supply_ok rose, saturating at the hold length
  logic [HCW-1:0] since_rst;
  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) since_rst <= '0;
    else if (since_rst < HCW'(DELAY_CYC)) since_rst <= since_rst + 1'b1;
  end

  AST_HOLD_BEFORE_READ: assert property (@(posedge clk) disable iff (!supply_ok)
    otp_req_valid && !instant_on |-> since_rst >= HCW'(DELAY_CYC)); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!supply_ok)
    otp_req_valid && !otp_req_ready |=> otp_req_valid && $stable(otp_req_addr)); // R9

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!supply_ok)
    cfg_wr_valid && !cfg_wr_ready |=> cfg_wr_valid && $stable(cfg_wr_addr) && $stable(cfg_wr_data)); // R9

  AST_WR_AFTER_CHECK: assert property (@(posedge clk) disable iff (!supply_ok)
    cfg_wr_valid |-> sum_ok_q); // R8

  AST_EN_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(out_en) |-> done && !csum_err); // R7

  AST_ERR_BLOCKS_EN: assert property (@(posedge clk) disable iff (!supply_ok)
    csum_err |-> !out_en); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!supply_ok)
    done |=> !done); // R12

endmodule

// File: tb/sim_cfg_boot_seq.sv
module sim_cfg_boot_seq;

  localparam int DELAY     = 40;
  localparam int NB        = 7;
  localparam int NS        = 4;
  localparam int BWORDS    = 8;
  localparam int WPB       = BWORDS + 1;
  localparam int SLOT_BASE = NB * WPB;
  localparam int AW        = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          supply_ok, instant_on, reload_req;
  logic          otp_req_valid, otp_req_ready;
  logic [AW-1:0] otp_req_addr;
  logic          otp_rsp_valid;
  logic [7:0]    otp_rsp_data;
  logic          cfg_wr_valid, cfg_wr_ready;
  logic [2:0]    cfg_wr_addr;
  logic [7:0]    cfg_wr_data;
  logic          out_en, done, csum_err;

  cfg_boot_seq #(.DELAY_CYC(DELAY)) u0 (
    .clk(clk), .supply_ok(supply_ok), .instant_on(instant_on), .reload_req(reload_req),
    .otp_req_valid(otp_req_valid), .otp_req_ready(otp_req_ready), .otp_req_addr(otp_req_addr),
    .otp_rsp_valid(otp_rsp_valid), .otp_rsp_data(otp_rsp_data),
    .cfg_wr_valid(cfg_wr_valid), .cfg_wr_ready(cfg_wr_ready), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .out_en(out_en), .done(done), .csum_err(csum_err)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  int          done_cnt = 0;
  int          req_cnt = 0;
  bit          prev_done = 1'b0;
  bit          pend = 1'b0;
  int          lat = 0;
  logic [AW-1:0] pend_addr;
  logic [7:0]  otp_mem [0:SLOT_BASE+NS-1];
  logic [10:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_bank(input logic [31:0] sl);
    int b = 1;
    for (int k = 0; k < NS; k++)
      if (sl[8*k +: 8] >= 8'd1 && sl[8*k +: 8] <= 8'(NB)) b = int'(sl[8*k +: 8]);
    return b;
  endfunction

  function automatic logic [7:0] word_val(input int b, input int w, input logic [7:0] seed);
    return 8'(b * 37 + w * 11 + int'(seed));
  endfunction

  // Driver: fills OTP and pushes the RAM writes the requirements predict
  task automatic setup(input logic [31:0] sl, input logic [7:0] seed, input bit corrupt);
    int pb = exp_bank(sl);
    for (int b = 1; b <= NB; b++) begin
      logic [7:0] sum = 8'd0;
      for (int w = 0; w < BWORDS; w++) begin
        otp_mem[(b-1)*WPB + w] = word_val(b, w, seed);
        sum = sum + word_val(b, w, seed);
      end
      otp_mem[(b-1)*WPB + BWORDS] = (corrupt && b == pb) ? sum + 8'd1 : sum;
    end
    for (int k = 0; k < NS; k++) otp_mem[SLOT_BASE + k] = sl[8*k +: 8];
    exp_q.delete();
    if (!corrupt)
      for (int w = 0; w < BWORDS; w++) exp_q.push_back({3'(w), word_val(pb, w, seed)});
  endtask

  // OTP model, RAM sink and scoreboard monitor, all away from the active edge
  always @(negedge clk) begin
    logic [10:0] e;
    otp_rsp_valid = 1'b0;
    if (!supply_ok) pend = 1'b0;
    else if (pend) begin
      if (lat == 0) begin
        otp_rsp_valid = 1'b1;
        otp_rsp_data  = otp_mem[pend_addr];
        pend = 1'b0;
      end else lat--;
    end
    otp_req_ready = ($urandom % 4) != 0;
    if (otp_req_valid) begin
      req_cnt++;
      if (otp_req_ready) begin
        pend = 1'b1;
        pend_addr = otp_req_addr;
        lat = int'($urandom % 2);
      end
    end
    cfg_wr_ready = ($urandom % 3) != 0;
    if (cfg_wr_valid && cfg_wr_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected RAM write addr", int'(cfg_wr_addr), -1);
      else begin
        e = exp_q.pop_front();
        chk({cfg_wr_addr, cfg_wr_data} == e, "R7", "RAM write {addr,data}",
            int'({cfg_wr_addr, cfg_wr_data}), int'(e));
      end
    end
    if (done) begin
      done_cnt++;
      if (prev_done) chk(1'b0, "R12", "done high cycles", 2, 1);
    end
    prev_done = done;
  end

  task automatic wait_done();
    int t = 0;
    do begin @(negedge clk); t++; end while (!done && t < 4000);
    chk(done == 1'b1, "R12", "done seen before timeout", int'(done), 1);
  endtask

  task automatic pulse_reload();
    @(negedge clk); reload_req = 1'b1;
    @(negedge clk); reload_req = 1'b0;
  endtask

  initial begin
    #(20ns * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, d0, r0;
    supply_ok = 1'b0; instant_on = 1'b0; reload_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_en == 1'b0, "R1", "out_en in reset", int'(out_en), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    chk(csum_err == 1'b0, "R1", "csum_err in reset", int'(csum_err), 0);
    chk(otp_req_valid == 1'b0 && cfg_wr_valid == 1'b0, "R1", "stream valids in reset",
        int'({otp_req_valid, cfg_wr_valid}), 0);

    // no slot programmed: bank 1, full start-up hold
    setup(32'h0000_0000, 8'h10, 1'b0);
    supply_ok = 1'b1; n = 0;
    do begin @(negedge clk); n++; end while (!otp_req_valid && n < DELAY + 20);
    chk(n == DELAY, "R2", "edges before first request", n, DELAY);
    chk(out_en == 1'b0, "R2", "out_en during hold", int'(out_en), 0);
    wait_done();
    chk(out_en == 1'b1 && csum_err == 1'b0, "R5", "good bank 1 result", int'({out_en, csum_err}), 2);
    chk(exp_q.size() == 0, "R5", "bank 1 writes outstanding", exp_q.size(), 0);

    // slots 1 and 2 programmed: slot 2 wins (bank 5), reload skips hold
    setup(32'h0000_0502, 8'h21, 1'b0);
    pulse_reload();
    chk(otp_req_valid == 1'b1, "R10", "request one edge after reload", int'(otp_req_valid), 1);
    chk(out_en == 1'b0, "R10", "out_en cleared by reload", int'(out_en), 0);
    wait_done();
    chk(exp_q.size() == 0 && out_en == 1'b1, "R4", "slot 2 over slot 1", exp_q.size(), 0);

    // all four programmed: slot 4 wins (bank 6); reload mid-run ignored
    setup(32'h0603_0201, 8'h42, 1'b0);
    pulse_reload();
    d0 = done_cnt;
    repeat (5) @(negedge clk);
    reload_req = 1'b1; @(negedge clk); reload_req = 1'b0;
    wait_done();
    repeat (40) @(negedge clk);
    chk(done_cnt == d0 + 1, "R11", "pulses after mid-run reload", done_cnt - d0, 1);
    chk(exp_q.size() == 0, "R4", "slot 4 bank writes outstanding", exp_q.size(), 0);

    // slot 4 out of range (9), slot 3 blank: slot 2 wins (bank 7)
    setup(32'h0900_0703, 8'h5a, 1'b0);
    pulse_reload();
    wait_done();
    chk(exp_q.size() == 0 && out_en == 1'b1, "R4", "out-of-range slot skipped", exp_q.size(), 0);

    // bad checksum on bank 4, then reload in the done cycle
    setup(32'h0000_0004, 8'h77, 1'b1);
    pulse_reload();
    wait_done();
    chk(csum_err == 1'b1, "R8", "csum_err on mismatch", int'(csum_err), 1);
    chk(out_en == 1'b0, "R6", "out_en on mismatch", int'(out_en), 0);
    reload_req = 1'b1;
    @(negedge clk); reload_req = 1'b0;
    r0 = req_cnt; d0 = done_cnt;
    repeat (30) @(negedge clk);
    chk(req_cnt == r0, "R11", "requests after reload in done cycle", req_cnt - r0, 0);
    chk(done_cnt == d0 && csum_err == 1'b1, "R11", "status kept after ignored reload",
        int'(csum_err), 1);

    // idle reload clears error and reloads bank 1
    setup(32'h0000_0000, 8'h33, 1'b0);
    pulse_reload();
    chk(csum_err == 1'b0, "R10", "csum_err cleared by reload", int'(csum_err), 0);
    wait_done();
    chk(out_en == 1'b1 && exp_q.size() == 0, "R6", "valid sum loads RAM", exp_q.size(), 0);

    // supply drop, then instant-on start
    supply_ok = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_en == 1'b0 && done == 1'b0 && csum_err == 1'b0, "R1", "outputs after supply drop",
        int'({out_en, done, csum_err}), 0);
    instant_on = 1'b1;
    setup(32'h0000_0200, 8'h08, 1'b0);
    supply_ok = 1'b1; n = 0;
    do begin @(negedge clk); n++; end while (!otp_req_valid && n < DELAY + 20);
    chk(n == 1, "R3", "edges before first request with instant-on", n, 1);
    wait_done();
    chk(out_en == 1'b1 && exp_q.size() == 0, "R3", "instant-on load result", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule